// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of a UART. It samples four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator, data-carrier-detect) through a synchronizer. It reports their active-high levels in the upper nibble of an 8-bit status word. The lower nibble holds sticky change flags. A flag latches when its input changes and is cleared when the CPU reads the register.

When any flag is set and the interrupt is enabled, the block raises an interrupt request. In loopback mode the four levels come from the UART's own modem-control outputs, so software can test the flag and interrupt logic without external wiring. With hardware flow control enabled, a deasserted clear-to-send input stalls the transmitter, but only at a character boundary.

Top module: `modem_stat_reg`

## Requirements
- R1: Outside loopback, status bits 7, 6, 5 and 4 are the complements of pins `modem_n_i[3]` (carrier detect), `[2]` (ring), `[1]` (data set ready) and `[0]` (clear to send). A pin change appears on the third rising clock edge after it is driven.
- R2: In loopback, status bits 7, 6, 5 and 4 follow `mctl_i[3]`, `[2]`, `[1]` and `[0]` after one clock edge. These are aux output 2, aux output 1, terminal ready and request-to-send.
- R3: Status bit 3 sets on any change of bit 7. Bit 1 sets on any change of bit 5. Bit 0 sets on any change of bit 4.
- R4: Status bit 2 sets only when bit 6 goes from 0 to 1. A 1-to-0 transition of bit 6 leaves it clear.
- R5: A one-cycle `rd_i` pulse clears all four flags on that clock edge.
- R6: A change that lands on the same edge as a read leaves its flag set.
- R7: Without a read, a set flag stays set.
- R8: `irq_o` is high exactly when `irq_en_i` is high and at least one flag is set.
- R9: Reset clears the whole status word and `irq_o`. During the first SYNC_STAGES+1 edges after reset no flag is set, while the upper nibble takes on the current source levels.
- R10: `tx_hold_o` changes only on edges where `tx_busy_i` is low. There it becomes `fc_en_i` AND NOT status bit 4.
- R11: In loopback, changes of the looped-back sources set the flags by the same rules as pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| modem_n_i | input | 4 | Active-low modem pins: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| loop_en_i | input | 1 | Loopback mode select |
| mctl_i | input | 4 | Modem-control outputs: [0] RTS, [1] DTR, [2] OUT1, [3] OUT2 |
| rd_i | input | 1 | Register read strobe, one cycle |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| fc_en_i | input | 1 | Hardware flow control enable |
| tx_busy_i | input | 1 | Transmitter is mid-character |
| status_o | output | 8 | Status word: levels [7:4], change flags [3:0] |
| irq_o | output | 1 | Modem-status interrupt request |
| tx_hold_o | output | 1 | Stall request to the transmitter |

## Verification
Some properties are checked on every cycle:
- A flag can only rise together with a matching move of its level bit, and the ring flag only on a rising level.
- Flags never drop without a read, and a read leaves only flags that were freshly earned.
- The loopback mirror and the interrupt gating hold.
- The hold output stays frozen while a character is in flight.

Other behaviour only the bench scenarios can show:
- The three-edge pin latency.
- Flags staying quiet while the synchronizer settles after reset.
- A change that collides with a read surviving it.
- Every genuine change being caught.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int unsigned NSIG    = 4;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_DCD = 3;
  typedef logic [NSIG-1:0] sig_vec_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= {W{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mstat_flag.sv
module mstat_flag #(
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic lvl_i,
  input  logic lvl_q_i,
  input  logic clr_i,
  output logic flag_o
);
  logic hit;
  logic flag_q;

  generate
    if (RISE_ONLY) begin : g_rise
      assign hit = lvl_i & ~lvl_q_i;
    end else begin : g_any
      assign hit = lvl_i ^ lvl_q_i;
    end
  endgenerate

  // new event wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~clr_i) | (arm_i & hit);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mstat_txgate.sv
module mstat_txgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fc_en_i,
  input  logic cts_lvl_i,
  input  logic busy_i,
  output logic hold_o
);
  logic hold_q;

  // only re-evaluated between characters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (!busy_i) hold_q <= fc_en_i & ~cts_lvl_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
  import modem_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] modem_n_i,
  input  logic       loop_en_i,
  input  logic [3:0] mctl_i,
  input  logic       rd_i,
  input  logic       irq_en_i,
  input  logic       fc_en_i,
  input  logic       tx_busy_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       tx_hold_o
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;
  localparam int unsigned CW     = $clog2(SETTLE + 1);

  sig_vec_t   pin_s;
  sig_vec_t   src_lvl;
  sig_vec_t   lvl_q;
  sig_vec_t   flag;
  logic [CW-1:0] settle_q;
  logic       arm;

  mstat_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (modem_n_i),
    .q_o   (pin_s)
  );

  assign src_lvl = loop_en_i ? mctl_i : ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= src_lvl;
  end

  // hold off flags until the synchronizer has filled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     settle_q <= '0;
    else if (settle_q != CW'(SETTLE)) settle_q <= settle_q + 1'b1;
  end
  assign arm = (settle_q == CW'(SETTLE));

  generate
    for (genvar i = 0; i < int'(NSIG); i++) begin : g_flag
      mstat_flag #(.RISE_ONLY(i == int'(IDX_RI))) u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm),
        .lvl_i  (src_lvl[i]),
        .lvl_q_i(lvl_q[i]),
        .clr_i  (rd_i),
        .flag_o (flag[i])
      );
    end
  endgenerate

  mstat_txgate u_txgate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fc_en_i  (fc_en_i),
    .cts_lvl_i(lvl_q[IDX_CTS]),
    .busy_i   (tx_busy_i),
    .hold_o   (tx_hold_o)
  );

  assign status_o = {lvl_q, flag};
  assign irq_o    = irq_en_i & (|flag);
endmodule

// File: rtl/modem_stat_chk.sv
module modem_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       loop_en_i,
  input logic [3:0] mctl_i,
  input logic       rd_i,
  input logic       irq_en_i,
  input logic       tx_busy_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       tx_hold_o
);
  logic [3:0] prev_hi;
  logic [3:0] earned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_hi <= '0;
    else         prev_hi <= status_o[7:4];
  end

  assign earned = {status_o[7] ^ prev_hi[3], status_o[6] & ~prev_hi[2],
                   status_o[5] ^ prev_hi[1], status_o[4] ^ prev_hi[0]};

  // R2
  lb_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |=> status_o[7:4] == $past(mctl_i));

  // R3
  dcd_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> status_o[7] != prev_hi[3]);

  // R3
  dsr_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> status_o[5] != prev_hi[1]);

  // R3
  cts_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> status_o[4] != prev_hi[0]);

  // R4
  ri_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> (status_o[6] && !prev_hi[2]));

  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (status_o[3:0] & ~earned) == 4'b0);

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0]));

  // R8
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && status_o[3:0] != 4'b0) |-> irq_o);

  // R8
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || status_o[3:0] == 4'b0) |-> !irq_o);

  // R10
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> $stable(tx_hold_o));
endmodule

bind modem_stat_reg modem_stat_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .loop_en_i(loop_en_i),
  .mctl_i   (mctl_i),
  .rd_i     (rd_i),
  .irq_en_i (irq_en_i),
  .tx_busy_i(tx_busy_i),
  .status_o (status_o),
  .irq_o    (irq_o),
  .tx_hold_o(tx_hold_o)
);

// File: tb/sim_modem_stat_reg.sv
`timescale 1ns/1ps
module sim_modem_stat_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] modem_n_i = 4'hF;
  logic       loop_en_i = 1'b0;
  logic [3:0] mctl_i = 4'h0;
  logic       rd_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       fc_en_i = 1'b0;
  logic       tx_busy_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;
  logic       tx_hold_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [3:0] m_s1, m_s2, m_lvlq, m_flag;
  logic       m_hold;
  int         m_cnt;

  modem_stat_reg u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = 4'hF; m_s2 = 4'hF; m_lvlq = 4'h0; m_flag = 4'h0; m_hold = 1'b0; m_cnt = 0;
  endtask

  task automatic model_edge();
    logic [3:0] lvl, hit;
    lvl = loop_en_i ? mctl_i : ~m_s2;
    hit = {lvl[3] ^ m_lvlq[3], lvl[2] & ~m_lvlq[2], lvl[1] ^ m_lvlq[1], lvl[0] ^ m_lvlq[0]};
    m_flag = (m_flag & ~{4{rd_i}}) | ((m_cnt == 3) ? hit : 4'h0);
    if (!tx_busy_i) m_hold = fc_en_i & ~m_lvlq[0];
    m_lvlq = lvl;
    m_s2 = m_s1;
    m_s1 = modem_n_i;
    if (m_cnt < 3) m_cnt++;
  endtask

  task automatic tick();
    @(posedge clk_i);
    if (rst_ni) model_edge();
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_read();
    rd_i = 1'b1; tick(); rd_i = 1'b0;
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    modem_n_i = 4'b0111;  // carrier detect asserted through reset
    #23;
    chk("R9 reset status", status_o, 8'h00);
    chk("R9 reset irq", irq_o, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    ticks(5);
    chk("R9 settle no flags, level tracks", status_o, 8'h80);

    modem_n_i = 4'b1111; ticks(2);
    chk("R1 latency not yet", status_o, 8'h80);
    tick();
    chk("R1/R3 dcd drop seen with flag", status_o, 8'h08);
    irq_en_i = 1'b1; #1;
    chk("R8 irq when enabled", irq_o, 1'b1);
    do_read();
    chk("R5 read clears", status_o, 8'h00);
    chk("R8 irq low after clear", irq_o, 1'b0);

    modem_n_i[2] = 1'b0; ticks(3);
    chk("R4 ring rise flags", status_o, 8'h44);
    do_read();
    modem_n_i[2] = 1'b1; ticks(3);
    chk("R4 ring fall no flag", status_o, 8'h00);

    modem_n_i[0] = 1'b0; ticks(3);
    chk("R3 cts change", status_o, 8'h11);
    modem_n_i[1] = 1'b0; ticks(2);
    do_read();
    chk("R6 change at read survives", status_o, 8'h32);
    ticks(10);
    chk("R7 flags sticky", status_o, 8'h32);
    do_read();
    chk("R5 read clears flags", status_o, 8'h30);

    loop_en_i = 1'b1; mctl_i = 4'b0011; tick();
    chk("R2 loopback equal levels", status_o, 8'h30);
    mctl_i = 4'b1000; tick();
    chk("R2/R11 loopback changes flag", status_o, 8'h8B);
    mctl_i = 4'b1100; tick();
    chk("R11 loopback ring rise", status_o, 8'hCF);

    fc_en_i = 1'b1; tx_busy_i = 1'b1; ticks(2);
    chk("R10 hold waits for boundary", tx_hold_o, 1'b0);
    tx_busy_i = 1'b0; tick();
    chk("R10 hold at boundary", tx_hold_o, 1'b1);
    tx_busy_i = 1'b1; mctl_i = 4'b1101; ticks(2);
    chk("R10 hold kept mid-char", tx_hold_o, 1'b1);
    tx_busy_i = 1'b0; tick();
    chk("R10 release at boundary", tx_hold_o, 1'b0);
    fc_en_i = 1'b0; mctl_i = 4'b1100; ticks(2);
    chk("R10 no hold when disabled", tx_hold_o, 1'b0);
    irq_en_i = 1'b0; #1;
    chk("R8 irq masked", irq_o, 1'b0);

    void'($urandom(32'h5eed1234));
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 7) == 0) modem_n_i[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 63) == 0) loop_en_i = ~loop_en_i;
      if ($urandom_range(0, 5) == 0) mctl_i = 4'($urandom);
      rd_i      = ($urandom_range(0, 7) == 0);
      irq_en_i  = ($urandom_range(0, 3) != 0);
      fc_en_i   = ($urandom_range(0, 3) != 0);
      tx_busy_i = ($urandom_range(0, 2) != 0);
      tick();
      chk("R1/R3/R4/R6 status vs reference", status_o, {m_lvlq, m_flag});
      chk("R8 irq vs reference", irq_o, irq_en_i & (|m_flag));
      chk("R10 hold vs reference", tx_hold_o, m_hold);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule